// File: doc/BRIEF.md
# Sticky Rising-Edge Capture Flag

This block watches a signal that is not tied to the system clock and reports any rising edge on it through a flag that stays set. A slow host polls the flag at its own pace and never misses an edge. If several edges arrive between two polls, they merge into one set flag, and no count of them is kept.

The input first passes through a two-stage synchronizer. An edge detector then compares the synchronized level with its value one cycle earlier. A detected rise sets the flag. The host reads a 1 and then raises an acknowledge request.

A one-shot turns the rising edge of that request into an internal clear pulse of exactly `CLR_CYCLES` cycles, however long the request is held. The clear-busy output is high while the pulse runs. An input rise that is evaluated during the pulse may be lost, so the lost-edge window is bounded by `CLR_CYCLES`.

There is no data stream here, only control and status pins, so no valid/ready handshake applies. The host is assumed to drive the acknowledge request from the block's own clock domain.

Top module: `sticky_edge_capture`

## Requirements
- R1: When the input is first sampled high at clock edge k, after being sampled low at edge k-1, `flag_o` reads 1 after edge k+2. This holds unless a clear is active at edge k+2.
- R2: Once set, `flag_o` stays 1 after the input falls again, for as long as no clear pulse is active.
- R3: Several input rises before an acknowledge leave `flag_o` at 1 and nothing more. After one clear, `flag_o` stays 0 until a new rise arrives.
- R4: When `ack_req_i` is sampled 1 at edge k and was sampled 0 at edge k-1, with no pulse running, `clr_busy_o` is 1 after edge k. At the edge that follows, `flag_o` becomes 0.
- R5: `clr_busy_o` stays high for exactly `CLR_CYCLES` consecutive cycles (default 2), whatever the duration of the request.
- R6: Holding `ack_req_i` high does not start a second pulse. A request rise sampled while a pulse is running is ignored.
- R7: The clear has priority over the set. At any edge where `clr_busy_o` was 1 before the edge, `flag_o` becomes 0, even if an input rise is evaluated at that edge, and that rise is dropped.
- R8: A synchronous active-high `rst` clears the flag, the pulse and the synchronizer. Both outputs read 0 during reset and after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sig_async_i | input | 1 | Monitored asynchronous signal |
| ack_req_i | input | 1 | Host acknowledge request (level; its rise triggers a clear) |
| flag_o | output | 1 | Sticky edge-seen flag |
| clr_busy_o | output | 1 | High while the internal clear pulse runs |

## Verification
The set path and the clear path can act in the same cycle: an input rise can reach the flag logic at an edge where the clear pulse is still active. The bench provokes this by raising the input one cycle before the acknowledge request. This places the detected rise inside the pulse window, and the bench expects the flag to stay 0. Randomized input and request patterns then let the two paths collide at every phase. On each clock, a behavioural model keeps the sampled histories and a countdown, and the bench compares both outputs against it.

// File: rtl/sticky_edge_capture_pkg.sv
package sticky_edge_capture_pkg;
  localparam int unsigned DEF_SYNC_STAGES = 2;
  localparam int unsigned DEF_CLR_CYCLES  = 2;

  function automatic int unsigned cnt_width(input int unsigned max_val);
    int unsigned w;
    w = 1;
    while ((1 << w) <= max_val) w++;
    return w;
  endfunction
endpackage

// File: rtl/sec_sync.sv
module sec_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic level_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= 1'b0;
          else     chain_q[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[g] <= 1'b0;
          else     chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign level_o = chain_q[STAGES-1];
endmodule

// File: rtl/sec_oneshot.sv
module sec_oneshot
  import sticky_edge_capture_pkg::*;
#(
  parameter int unsigned CLR_CYCLES = DEF_CLR_CYCLES
) (
  input  logic clk,
  input  logic rst,
  input  logic ack_i,
  output logic busy_o
);
  localparam int unsigned CW = cnt_width(CLR_CYCLES);
  localparam logic [CW-1:0] LOAD = CW'(CLR_CYCLES);

  logic          ack_q;
  logic [CW-1:0] cnt_q;
  logic          ack_rise;

  assign ack_rise = ack_i & ~ack_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      ack_q <= ack_i;
      if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
      else if (ack_rise) cnt_q <= LOAD;
    end
  end

  assign busy_o = (cnt_q != '0);

  // Checker-side run length counter
  logic [CW:0] run_q;
  always_ff @(posedge clk) begin
    if (rst)         run_q <= '0;
    else if (busy_o) run_q <= run_q + 1'b1;
    else             run_q <= '0;
  end

  a_r5_pulse_len: assert property (@(posedge clk) disable iff (rst)
    run_q <= (CW+1)'(CLR_CYCLES));
  a_r5_pulse_full: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && run_q != '0) |-> run_q == (CW+1)'(CLR_CYCLES));
  a_r4_start: assert property (@(posedge clk) disable iff (rst)
    (ack_i && !ack_q && !busy_o) |=> busy_o);
  a_r6_no_retrig: assert property (@(posedge clk) disable iff (rst)
    (ack_i && ack_q && !busy_o) |=> !busy_o);
endmodule

// File: rtl/sec_flag.sv
module sec_flag (
  input  logic clk,
  input  logic rst,
  input  logic level_i,
  input  logic clr_i,
  output logic flag_o
);
  logic prev_q;
  logic flag_q;
  logic rise;

  assign rise = level_i & ~prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      prev_q <= level_i;
      if (clr_i)     flag_q <= 1'b0;
      else if (rise) flag_q <= 1'b1;
    end
  end

  assign flag_o = flag_q;

  a_r2_sticky: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !clr_i) |=> flag_q);
  a_r7_clear_wins: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> !flag_q);
  a_r1_set: assert property (@(posedge clk) disable iff (rst)
    (rise && !clr_i) |=> flag_q);
endmodule

// File: rtl/sticky_edge_capture.sv
module sticky_edge_capture
  import sticky_edge_capture_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES,
  parameter int unsigned CLR_CYCLES  = DEF_CLR_CYCLES
) (
  input  logic clk,
  input  logic rst,
  input  logic sig_async_i,
  input  logic ack_req_i,
  output logic flag_o,
  output logic clr_busy_o
);
  logic level_s;
  logic busy_s;

  sec_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_i(sig_async_i), .level_o(level_s));

  sec_oneshot #(.CLR_CYCLES(CLR_CYCLES)) u_oneshot (
    .clk(clk), .rst(rst), .ack_i(ack_req_i), .busy_o(busy_s));

  sec_flag u_flag (
    .clk(clk), .rst(rst), .level_i(level_s), .clr_i(busy_s), .flag_o(flag_o));

  assign clr_busy_o = busy_s;

  a_r8_reset: assert property (@(posedge clk)
    rst |=> (!flag_o && !clr_busy_o));
endmodule

// File: tb/test_sticky_edge_capture.sv
module test_sticky_edge_capture;
  localparam time CLK_PERIOD = 10ns;
  localparam int  CLR = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sig = 1'b0;
  logic ack = 1'b0;
  logic flag, busy;

  int compared = 0;
  int mismatched = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sticky_edge_capture #(.SYNC_STAGES(2), .CLR_CYCLES(CLR)) i_sticky_edge_capture (
    .clk(clk), .rst(rst), .sig_async_i(sig), .ack_req_i(ack),
    .flag_o(flag), .clr_busy_o(busy));

  // Behavioural reference: sampled histories plus a countdown
  int in_h[$];
  int ack_h[$];
  int rem = 0;
  bit m_flag = 0;
  bit m_busy = 0;

  initial begin
    for (int i = 0; i < 4; i++) begin in_h.push_back(0); ack_h.push_back(0); end
  end

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 4; i++) begin in_h[i] = 0; ack_h[i] = 0; end
      rem = 0; m_flag = 0;
    end else begin
      bit rise_n, arise, busy_pre;
      in_h.push_back(int'(sig));  void'(in_h.pop_front());
      ack_h.push_back(int'(ack)); void'(ack_h.pop_front());
      rise_n   = (in_h[1] == 1) && (in_h[0] == 0);
      arise    = (ack_h[3] == 1) && (ack_h[2] == 0);
      busy_pre = (rem > 0);
      if (busy_pre)    m_flag = 0;
      else if (rise_n) m_flag = 1;
      if (rem > 0)     rem--;
      else if (arise)  rem = CLR;
    end
    m_busy = (rem > 0);
  end

  bit model_on = 0;
  always @(negedge clk) begin
    if (model_on) begin
      compared++;
      if (flag !== m_flag) begin
        mismatched++;
        $display("FAIL R2 model flag: actual %0b expected %0b at %0t", flag, m_flag, $time);
      end
      compared++;
      if (busy !== m_busy) begin
        mismatched++;
        $display("FAIL R5 model busy: actual %0b expected %0b at %0t", busy, m_busy, $time);
      end
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int busy_len;
    cyc(3);
    chk("R8 reset flag", flag, 1'b0);
    chk("R8 reset busy", busy, 1'b0);
    rst = 1'b0;
    model_on = 1;
    cyc(2);

    // R1 latency: sampled high at edge k, flag set after k+2
    sig = 1'b1;
    cyc(1); chk("R1 after k", flag, 1'b0);
    cyc(1); chk("R1 after k+1", flag, 1'b0);
    cyc(1); chk("R1 after k+2", flag, 1'b1);
    sig = 1'b0;
    cyc(5); chk("R2 sticky after fall", flag, 1'b1);

    // R3 several rises merge
    for (int p = 0; p < 3; p++) begin sig = 1'b1; cyc(2); sig = 1'b0; cyc(2); end
    cyc(3); chk("R3 merged flag", flag, 1'b1);

    // R4/R5/R6 ack held long
    ack = 1'b1;
    cyc(1); chk("R4 busy after ack edge", busy, 1'b1);
    chk("R4 flag before clear edge", flag, 1'b1);
    cyc(1); chk("R4 flag cleared", flag, 1'b0);
    busy_len = 1;
    for (int i = 0; i < 12; i++) begin
      if (busy) busy_len++;
      cyc(1);
    end
    chk("R5 pulse length", busy_len == CLR, 1'b1);
    chk("R6 held ack no retrigger", busy, 1'b0);
    ack = 1'b0;
    cyc(4); chk("R3 no count after clear", flag, 1'b0);

    // R6 ack rise while busy is ignored
    ack = 1'b1; cyc(1); ack = 1'b0; cyc(1); ack = 1'b1;
    cyc(CLR + 2); chk("R6 rise during pulse ignored", busy, 1'b0);
    ack = 1'b0; cyc(3);

    // R7 rise evaluated inside clear window is dropped
    sig = 1'b1; cyc(1);
    ack = 1'b1; cyc(1); ack = 1'b0;
    cyc(6); chk("R7 rise during clear dropped", flag, 1'b0);
    sig = 1'b0; cyc(3);

    // Random collisions, model compare every clock
    for (int i = 0; i < 3000; i++) begin
      sig = ($urandom_range(0, 3) == 0) ? ~sig : sig;
      ack = ($urandom_range(0, 5) == 0) ? ~ack : ack;
      cyc(1);
    end

    // R8 reset mid-operation
    sig = 1'b1; cyc(4); ack = 1'b1;
    @(negedge clk); rst = 1'b1; model_on = 0;
    cyc(2);
    chk("R8 reset flag mid-run", flag, 1'b0);
    chk("R8 reset busy mid-run", busy, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule